// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps a small set of sticky flags that tell software which event brought the system out of its most recent reset. Four causes are tracked: watchdog timeout, supply brown-out, the external reset pin, and power-on. The reset controller feeds each non-power-on cause in as a single-cycle pulse that is synchronous to the register clock. Each pulse sets its flag, and the flag then holds until software clears it.

Power-on is the register's own reset input. It sets the power-on flag and clears the other three. Software sees one byte. The flags sit in the low nibble and the high nibble always reads zero. Writing a zero to a flag bit clears that flag. Writing a one leaves the flag as it is, so a read-modify-write cannot create a false cause. Early boot code reads the byte and then writes zeros to it. After the next reset, the flags then show only the new cause or causes.

Top module: `reset_cause_reg`

## Requirements
- R1: While `por_rst` is high at a clock edge, the register loads 8'h01 (power-on flag set in bit 0, all others clear), whatever the other inputs do in that cycle.
- R2: Bits 7 to 4 of `rd_data` always read zero, including after a write of ones to those bits.
- R3: A one-cycle pulse on `wdt_evt`, `bod_evt` or `ext_evt` sets bit 3, bit 2 or bit 1 respectively, visible on `rd_data` after that clock edge.
- R4: Flags from different causes accumulate, whether their pulses arrive together or in separate cycles.
- R5: A write (`wr_en` high) with a zero in bit n of `wr_data` (n = 0..3) clears flag n at that clock edge.
- R6: A write with a one in a flag bit leaves that flag unchanged and never sets it.
- R7: When a cause pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: The power-on flag (bit 0) is cleared only by a zero write, and no cause pulse sets it.
- R9: With no pulse and no write, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| wdt_evt | input | 1 | Watchdog reset cause pulse |
| bod_evt | input | 1 | Brown-out reset cause pulse |
| ext_evt | input | 1 | External pin reset cause pulse |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Write byte; a zero in a flag bit clears that flag |
| rd_data | output | 8 | Flag byte: bit3 watchdog, bit2 brown-out, bit1 external, bit0 power-on |

## Verification
The bench targets three collisions.

- **Cause pulse and clearing write on the same flag in the same cycle.** A design where the clear takes priority would lose the cause that just occurred.
- **Write of all ones.** A design that loads the bus would invent causes, and it would also expose bits in the reserved upper nibble.
- **Power-on asserted while other cause pulses are active.** A design that lets those pulses through would report a mixed cause after power-up.

The bench also confirms that the power-on flag can be cleared by software and that cause pulses never set it again afterwards.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int BUS_W     = 8;
  localparam int POR_BIT   = 0;
  localparam int EXT_BIT   = 1;
  localparam int BOD_BIT   = 2;
  localparam int WDT_BIT   = 3;
  localparam int RSV_W     = BUS_W - NUM_FLAGS;
  localparam logic [NUM_FLAGS-1:0] POR_VALUE = NUM_FLAGS'(1) << POR_BIT;
endpackage

// File: rtl/rcf_flag_cell.sv
module rcf_flag_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);

  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !q_o) |=> !q_o);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/rcf_readback.sv
module rcf_readback
  import rcf_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [BUS_W-1:0]     bus_o
);
  always_comb begin
    bus_o = '0;
    bus_o[NUM_FLAGS-1:0] = flags_i;
  end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcf_pkg::*;
(
  input  logic             clk,
  input  logic             por_rst,
  input  logic             wdt_evt,
  input  logic             bod_evt,
  input  logic             ext_evt,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data
);
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flag_q;

  always_comb begin
    set_vec          = '0;
    set_vec[WDT_BIT] = wdt_evt;
    set_vec[BOD_BIT] = bod_evt;
    set_vec[EXT_BIT] = ext_evt;
    clr_vec          = {NUM_FLAGS{wr_en}} & ~wr_data[NUM_FLAGS-1:0];
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    rcf_flag_cell #(.RST_VAL(POR_VALUE[i])) u_cell (
      .clk   (clk),
      .rst   (por_rst),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flag_q[i])
    );
  end

  rcf_readback u_rb (
    .flags_i (flag_q),
    .bus_o   (rd_data)
  );

  // R1
  por_value_chk: assert property (@(posedge clk)
    por_rst |=> (rd_data == BUS_W'(POR_VALUE)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (por_rst)
    (wr_en && (wr_data[BUS_W-1:NUM_FLAGS] != '0)) |=> (rd_data[BUS_W-1:NUM_FLAGS] == '0));

  // R8
  por_no_reset_chk: assert property (@(posedge clk) disable iff (por_rst)
    !rd_data[POR_BIT] |=> !rd_data[POR_BIT]);

  // R3
  cause_set_chk: assert property (@(posedge clk) disable iff (por_rst)
    (wdt_evt || bod_evt || ext_evt) |=>
      ((rd_data[WDT_BIT] || !$past(wdt_evt)) && (rd_data[BOD_BIT] || !$past(bod_evt)) &&
       (rd_data[EXT_BIT] || !$past(ext_evt))));
endmodule

// File: tb/tb_reset_cause_reg.sv
module tb_reset_cause_reg;
  logic       clk = 1'b0;
  logic       por_rst;
  logic       wdt_evt, bod_evt, ext_evt, wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #2 clk = ~clk;

  reset_cause_reg dut (.*);

  // fields: req[23:20] wdt bod ext wr_en wr_data[7:0] expected[7:0]
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {4'd3, 4'b1000, 8'h00, 8'h09},  // R3 watchdog sets bit 3
    {4'd4, 4'b0100, 8'h00, 8'h0D},  // R4 brown-out accumulates
    {4'd9, 4'b0000, 8'h00, 8'h0D},  // R9 idle holds
    {4'd6, 4'b0001, 8'hFF, 8'h0D},  // R6 write ones changes nothing
    {4'd5, 4'b0001, 8'hF7, 8'h05},  // R5 zero in bit 3 clears it
    {4'd7, 4'b0011, 8'hFD, 8'h07},  // R7 ext set beats clear
    {4'd8, 4'b0001, 8'hFE, 8'h06},  // R8 power-on flag cleared by write
    {4'd4, 4'b1110, 8'h00, 8'h0E},  // R4 three causes together
    {4'd5, 4'b0001, 8'h00, 8'h00},  // R5 clear all
    {4'd6, 4'b0001, 8'h0F, 8'h00},  // R6 ones never set
    {4'd2, 4'b0001, 8'hF0, 8'h00},  // R2 reserved stay zero
    {4'd3, 4'b0010, 8'h00, 8'h02},  // R3 external sets bit 1
    {4'd7, 4'b1001, 8'h00, 8'h08}   // R7 watchdog set with full clear
  };

  task automatic check(input int req, input logic [7:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL R%0d: rd_data=%02h expected=%02h", req, rd_data, exp);
    end
  endtask

  task automatic step(input logic [3:0] ctl, input logic [7:0] d);
    {wdt_evt, bod_evt, ext_evt, wr_en} = ctl;
    wr_data = d;
    @(negedge clk);
    {wdt_evt, bod_evt, ext_evt, wr_en} = 4'b0;
    wr_data = 8'h00;
  endtask

  initial begin
    por_rst = 1'b1;
    {wdt_evt, bod_evt, ext_evt, wr_en} = 4'b0;
    wr_data = 8'h00;
    @(negedge clk); @(negedge clk);
    check(1, 8'h01);               // R1 reset state
    por_rst = 1'b0;
    @(negedge clk);
    check(1, 8'h01);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19:16], VEC[i][15:8]);
      check(int'(VEC[i][23:20]), VEC[i][7:0]);
    end
    // R8 causes never set the power-on flag
    step(4'b1110, 8'h00);
    check(8, 8'h0E);
    // R9 hold over several idle cycles
    repeat (5) @(negedge clk);
    check(9, 8'h0E);
    // R1 power-on with causes and write active
    por_rst = 1'b1;
    step(4'b1111, 8'hFF);
    check(1, 8'h01);
    por_rst = 1'b0;
    @(negedge clk);
    check(1, 8'h01);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9: watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule